// File: doc/BRIEF.md
# Voltage-Tracking Divisor Arbiter

This block chooses the next divisor for one clock divider, once per cycle of that divider's output clock. A larger divisor gives a slower clock. Four local voltage comparators each report one of three codes: go faster, go slower, or stay put. These codes arrive without any timing relation to the clock, so the block first passes them through a two-stage synchronizer. It then reduces them to a single local vote, using a programmable dead-zone threshold.

Each vote is broadcast to the other dividers of the same group. Each divider merges its own vote with the votes of its peers under a rule where slowing down always wins. Because every member of the group sees the same set of votes, every member makes the same step on the same edge. The group therefore stays at one common divisor and keeps its phase lock.

The block starts in fixed mode. In that mode the divisor follows the configured safe value and all comparator codes are ignored. Software moves the block to variable mode by setting a mode input. In variable mode the divisor moves by one unit per step. It stays between a lower bound, set by the fastest allowed clock, and an upper bound, the safe value.

Top module: `vdiv_arbiter`

## Requirements
- R1: While reset is low at a rising edge, the divisor loads `safe_div` and every synchronizer stage clears. After reset, `own_req` reads 2'b00 until a request has passed the synchronizer.
- R2: Each detector uses two bits. Detector i sits at `det_code[2i+1:2i]`, and the codes are: 2'b00 stay, 2'b01 faster, 2'b10 slower, 2'b11 treated as slower. In variable mode `own_req` carries the local vote, using the same encoding. The vote is 2'b10 if any synchronized detector asks for slower. Otherwise it is 2'b01 if the number of detectors asking for faster is strictly greater than `dz_width`. Otherwise it is 2'b00.
- R3: Each detector code passes through two flip-flop stages. A code held across one rising edge, and returned to stay before the next, changes the divisor exactly once. That change happens at the second rising edge after the capturing edge.
- R4: While `var_mode_en` is 0, `own_req` is 2'b00 and detector and peer inputs have no effect. At each edge the divisor takes the value `safe_div` had at that edge.
- R5: In variable mode, the merge looks at the own vote and every peer vote, each encoded as in R2. If any of them is slower (bit 1 set), the divisor rises by one. Otherwise, if any is faster, the divisor falls by one. Otherwise it is unchanged.
- R6: In variable mode the divisor never rises above `safe_div` and never falls below `limit_div`. A step that would cross either bound is ignored. If a change in the bounds leaves the divisor outside them, it is clamped to the nearest bound on the next edge.
- R7: The dead zone works as follows. If the number of faster requests is at most `dz_width`, and no detector asks for slower, the local vote is stay. When all votes in the group are stay, the divisor is unchanged.
- R8: Dividers wired in a group see the same configuration. Each one's `own_req` feeds the `peer_req` of every other. Under these conditions all of them hold the same divisor in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divider output clock |
| rst_n | input | 1 | Synchronous active-low reset |
| var_mode_en | input | 1 | 1 selects variable mode, 0 fixed mode |
| safe_div | input | DIV_W | Safe (slowest) divisor, upper bound |
| limit_div | input | DIV_W | Fastest allowed divisor, lower bound |
| dz_width | input | DZ_W | Faster requests must exceed this count |
| det_code | input | 2*N_DET | Asynchronous detector codes |
| peer_req | input | 2*N_PEER | Votes from peer dividers |
| own_req | output | 2 | Local vote broadcast to peers |
| div_out | output | DIV_W | Current divisor |

## Verification
The hardest case to reach from the ports is a group in which members disagree on the same edge. In that case one divider's comparators ask for faster while a peer's ask for slower, and lock must still hold. The bench builds a group of three instances and gives each its own detector pattern. It pulses each pattern for exactly one cycle, so that all conflicting votes leave the synchronizers on the same edge. A monitor compares the three divisors in every cycle. Further directed pulses walk the divisor onto both bounds and then move a bound past the divisor, which forces the clamp path.

// File: rtl/vdiv_arbiter.sv
module vdiv_arbiter #(
  parameter int DIV_W  = 6,
  parameter int N_DET  = 4,
  parameter int N_PEER = 2,
  parameter int DZ_W   = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                var_mode_en,
  input  logic [DIV_W-1:0]    safe_div,
  input  logic [DIV_W-1:0]    limit_div,
  input  logic [DZ_W-1:0]     dz_width,
  input  logic [2*N_DET-1:0]  det_code,
  input  logic [2*N_PEER-1:0] peer_req,
  output logic [1:0]          own_req,
  output logic [DIV_W-1:0]    div_out
);
  localparam int CNT_W = $clog2(N_DET + 1);
  localparam int CMP_W = CNT_W + DZ_W;

  logic [2*N_DET-1:0] sync_a, sync_b;
  logic               any_slow;
  logic [CNT_W-1:0]   n_fast;
  logic               fast_ok;
  logic               grp_slow, grp_fast;
  logic [DIV_W-1:0]   div_nxt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_a <= '0;
      sync_b <= '0;
    end else begin
      sync_a <= det_code;
      sync_b <= sync_a;
    end
  end

  always_comb begin
    any_slow = 1'b0;
    n_fast   = '0;
    for (int i = 0; i < N_DET; i++) begin
      if (sync_b[2*i+1])
        any_slow = 1'b1;
      else if (sync_b[2*i])
        n_fast = n_fast + CNT_W'(1);
    end
  end

  assign fast_ok = CMP_W'(n_fast) > CMP_W'(dz_width);

  assign own_req = !var_mode_en ? 2'b00 :
                   any_slow     ? 2'b10 :
                   fast_ok      ? 2'b01 : 2'b00;

  always_comb begin
    grp_slow = own_req[1];
    grp_fast = own_req[0] & ~own_req[1];
    for (int p = 0; p < N_PEER; p++) begin
      grp_slow = grp_slow | peer_req[2*p+1];
      grp_fast = grp_fast | (peer_req[2*p] & ~peer_req[2*p+1]);
    end
  end

  always_comb begin
    if (!var_mode_en)
      div_nxt = safe_div;
    else if (div_out > safe_div)
      div_nxt = safe_div;
    else if (div_out < limit_div)
      div_nxt = limit_div;
    else if (grp_slow)
      div_nxt = (div_out < safe_div) ? div_out + DIV_W'(1) : div_out;
    else if (grp_fast)
      div_nxt = (div_out > limit_div) ? div_out - DIV_W'(1) : div_out;
    else
      div_nxt = div_out;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      div_out <= safe_div;
    else
      div_out <= div_nxt;
  end
endmodule

// File: rtl/vdiv_arbiter_chk.sv
module vdiv_arbiter_chk #(
  parameter int DIV_W  = 6,
  parameter int N_PEER = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                var_mode_en,
  input logic [DIV_W-1:0]    safe_div,
  input logic [DIV_W-1:0]    limit_div,
  input logic [2*N_PEER-1:0] peer_req,
  input logic [1:0]          own_req,
  input logic [DIV_W-1:0]    div_out
);
  logic in_rng;
  assign in_rng = (div_out >= limit_div) && (div_out <= safe_div);

  AST_FIXED_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
    !var_mode_en |=> div_out == $past(safe_div)); // R4

  AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (var_mode_en && in_rng) |=>
      (div_out == $past(div_out) || div_out == $past(div_out) + DIV_W'(1) ||
       div_out + DIV_W'(1) == $past(div_out))); // R5

  AST_IN_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
    (var_mode_en && in_rng) |=>
      (div_out >= $past(limit_div) && div_out <= $past(safe_div))); // R6

  AST_SLOW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (var_mode_en && own_req[1] && in_rng && div_out < safe_div) |=>
      div_out == $past(div_out) + DIV_W'(1)); // R5

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (var_mode_en && in_rng && own_req == 2'b00 && peer_req == '0) |=>
      $stable(div_out)); // R7
endmodule

bind vdiv_arbiter vdiv_arbiter_chk #(.DIV_W(DIV_W), .N_PEER(N_PEER)) u_chk (
  .clk(clk), .rst_n(rst_n), .var_mode_en(var_mode_en), .safe_div(safe_div),
  .limit_div(limit_div), .peer_req(peer_req), .own_req(own_req), .div_out(div_out));

// File: tb/vdiv_arbiter_test.sv
module vdiv_arbiter_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic var_mode = 1'b0;
  logic [5:0] safe = 6'd40, limit = 6'd8;
  logic [2:0] dz = 3'd0;
  logic [7:0] det_u = '0, det_a = '0, det_b = '0;
  logic [1:0] own_u, own_a, own_b;
  logic [5:0] div_u, div_a, div_b;
  int checks = 0, errors = 0, lock_err = 0;
  logic [1:0] last_own;

  always #(CLK_PERIOD/2) clk = ~clk;

  vdiv_arbiter uut (.clk(clk), .rst_n(rst_n), .var_mode_en(var_mode), .safe_div(safe),
    .limit_div(limit), .dz_width(dz), .det_code(det_u), .peer_req({own_b, own_a}),
    .own_req(own_u), .div_out(div_u));
  vdiv_arbiter peer_a (.clk(clk), .rst_n(rst_n), .var_mode_en(var_mode), .safe_div(safe),
    .limit_div(limit), .dz_width(dz), .det_code(det_a), .peer_req({own_b, own_u}),
    .own_req(own_a), .div_out(div_a));
  vdiv_arbiter peer_b (.clk(clk), .rst_n(rst_n), .var_mode_en(var_mode), .safe_div(safe),
    .limit_div(limit), .dz_width(dz), .det_code(det_b), .peer_req({own_a, own_u}),
    .own_req(own_b), .div_out(div_b));

  // R8: group lock monitored every cycle
  always @(negedge clk)
    if (rst_n && (div_u != div_a || div_u != div_b)) lock_err++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one-cycle pulse of detector codes; step: +1 slower, -1 faster, 0 none
  task automatic pulse(input logic [7:0] du, input logic [7:0] da, input logic [7:0] db,
                       input int step);
    int prev = int'(div_u);
    int exp = prev + step;
    if (step > 0 && prev >= int'(safe)) exp = prev;
    if (step < 0 && prev <= int'(limit)) exp = prev;
    det_u = du; det_a = da; det_b = db;
    @(posedge clk); @(negedge clk);
    det_u = '0; det_a = '0; det_b = '0;
    @(posedge clk); @(negedge clk);
    last_own = own_u;
    chk(div_u == 6'(prev), "R3 latency", div_u, prev);
    @(posedge clk); @(negedge clk);
    chk(div_u == 6'(exp), "R5 step", div_u, exp);
    @(posedge clk); @(negedge clk);
    chk(div_u == 6'(exp), "R3 single change", div_u, exp);
  endtask

  // {dz, det_u, det_a, det_b, step: 00 none, 01 faster, 10 slower}
  localparam logic [28:0] VEC [12] = '{
    {3'd0, 8'h00, 8'h00, 8'h00, 2'b00},  // R7 all stay
    {3'd0, 8'h01, 8'h00, 8'h00, 2'b01},  // R2 one faster
    {3'd0, 8'h01, 8'h02, 8'h00, 2'b10},  // R5 slower wins over peer faster
    {3'd1, 8'h05, 8'h00, 8'h00, 2'b01},  // R7 two faster beats width 1
    {3'd2, 8'h05, 8'h00, 8'h00, 2'b00},  // R7 two faster inside width 2
    {3'd2, 8'h00, 8'h00, 8'h15, 2'b01},  // R5 peer-only faster
    {3'd0, 8'h03, 8'h00, 8'h00, 2'b10},  // R2 code 11 is slower
    {3'd0, 8'h40, 8'h40, 8'h00, 2'b01},  // R2 detector 3 faster
    {3'd4, 8'h55, 8'h55, 8'h55, 2'b00},  // R7 four faster inside width 4
    {3'd3, 8'h00, 8'h55, 8'h00, 2'b01},  // R7 four beats width 3
    {3'd0, 8'h55, 8'h00, 8'h80, 2'b10},  // R5 one peer slower wins
    {3'd0, 8'hAA, 8'h00, 8'h00, 2'b10}   // R2 all slower
  };

  initial begin
    #(CLK_PERIOD * 20000);
    chk(1'b0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    chk(div_u == 6'd40, "R1 reset divisor", div_u, 40);
    chk(own_u == 2'b00, "R1 reset vote", own_u, 0);

    // R4: fixed mode ignores requests and tracks safe value
    det_u = 8'h01;
    repeat (3) @(negedge clk);
    chk(own_u == 2'b00, "R4 vote silent", own_u, 0);
    det_u = '0;
    pulse(8'h55, 8'h55, 8'hAA, 0);
    safe = 6'd44;
    @(posedge clk); @(negedge clk);
    chk(div_u == 6'd44, "R4 tracks safe", div_u, 44);
    safe = 6'd40;
    @(posedge clk); @(negedge clk);
    var_mode = 1'b1;
    @(posedge clk); @(negedge clk);

    // R2: broadcast vote
    pulse(8'h01, 8'h00, 8'h00, -1);
    chk(last_own == 2'b01, "R2 own faster", last_own, 1);
    pulse(8'h08, 8'h00, 8'h00, 1);
    chk(last_own == 2'b10, "R2 own slower", last_own, 2);

    for (int k = 0; k < 12; k++) begin
      dz = VEC[k][28:26];
      pulse(VEC[k][25:18], VEC[k][17:10], VEC[k][9:2],
            VEC[k][1:0] == 2'b01 ? -1 : (VEC[k][1:0] == 2'b10 ? 1 : 0));
    end
    dz = 3'd0;

    // R6: bounds
    pulse(8'hAA, 8'h00, 8'h00, 1);
    chk(div_u == 6'd40, "R6 reach safe", div_u, 40);
    pulse(8'hAA, 8'h00, 8'h00, 1);
    chk(div_u == 6'd40, "R6 hold at safe", div_u, 40);
    limit = 6'd38;
    pulse(8'h01, 8'h00, 8'h00, -1);
    pulse(8'h01, 8'h00, 8'h00, -1);
    pulse(8'h00, 8'h00, 8'h01, -1);
    chk(div_u == 6'd38, "R6 hold at limit", div_u, 38);
    limit = 6'd39;
    @(posedge clk); @(negedge clk);
    chk(div_u == 6'd39, "R6 clamp to limit", div_u, 39);

    // R4: return to fixed mode
    var_mode = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(div_u == 6'd40, "R4 back to safe", div_u, 40);

    chk(lock_err == 0, "R8 group lock", lock_err, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule